// File: doc/BRIEF.md
# Dual-Select Static RAM Write-Window Model

A cycle-based behavioural model of a byte-wide static RAM. It is meant as the target device when an SRAM controller is verified. The model sees four asynchronous control levels: an active-low select, an active-high select, an active-low write strobe and an active-low output enable. It samples them on a fast simulation clock, so every timing quantity is expressed in sample ticks.

A write is not tied to a clock edge. It is the interval in which both selects are asserted and the write strobe is low. Any of those three levels can open the interval, and any of them can close it. The byte is committed to the array when the interval closes. The commit uses the data and address seen on the last sample inside the interval.

Reads follow the device truth table. Drive enable and data are registered one tick behind the control sample. The model also checks the controller's timing. It raises single-tick flags for a write interval that is too short, for data that settled too late before the interval closed, and for write starts that follow each other too closely. It flags bus contention when it drives the data bus while the controller also drives it.

Top module: `sramw_model`

## Requirements
- R1: A write interval exists only on samples where `cs1_ni`=0, `cs2_i`=1 and `we_ni`=0. On any other combination, no array location changes, whatever `din_i` and `addr_i` carry.
- R2: The interval opens on the first sample where the last of the three conditions becomes true. It closes on the first sample where any one of them is false. Raising `we_ni`, raising `cs1_ni` or lowering `cs2_i` each close it, and each closing commits the byte.
- R3: The committed byte and address are the `din_i` and `addr_i` values sampled on the last tick inside the interval. A change of `din_i` during the interval is honoured.
- R4: One tick after a sample with `cs1_ni`=0, `cs2_i`=1, `we_ni`=1 and `oe_ni`=0, `dout_en_o`=1 and `dout_o` holds the array byte at the sampled `addr_i`. A byte committed on a closing tick is already visible in that same read.
- R5: While the read condition is held and `addr_i` changes, `dout_o` shows the byte of the new address one tick later.
- R6: One tick after any sample with `cs1_ni`=1 or `cs2_i`=0, `dout_en_o`=0 and `dout_o`=0, regardless of `we_ni`, `oe_ni` and `ext_drv_i`.
- R7: One tick after any sample inside a write interval, `dout_en_o`=0. This includes an interval opened by `cs1_ni` and `we_ni` falling on the same sample.
- R8: One tick after a selected sample with `oe_ni`=1, `dout_en_o`=0 and `dout_o`=0.
- R9: `wp_viol_o` pulses for one tick, on the tick after closing, when the interval lasted fewer than TWP_TICKS samples. The byte is still committed.
- R10: `dw_viol_o` pulses for one tick, on the tick after closing, when the committed byte had been present on `din_i` for fewer than TDW_TICKS consecutive samples.
- R11: `wc_viol_o` pulses for one tick, on the tick after an opening, when fewer than TWC_TICKS samples separate it from the previous opening. Opening samples are not counted in that distance.
- R12: `contention_o`=1 exactly while `dout_en_o`=1 and `ext_drv_i`=1.
- R13: While `rst_ni` is low and after it is released, with the device deselected, all outputs are 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | Select, active low |
| cs2_i | input | 1 | Select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Write data from the controller |
| ext_drv_i | input | 1 | Controller is driving the data bus |
| dout_o | output | DATA_W | Read data, 0 when not driving |
| dout_en_o | output | 1 | Model drives the bus (0 means high impedance) |
| wp_viol_o | output | 1 | Write interval too short |
| dw_viol_o | output | 1 | Write data settled too late |
| wc_viol_o | output | 1 | Write starts too close together |
| contention_o | output | 1 | Both sides drive the bus |

## Verification
The checker evaluates every cycle that drive enable follows the truth table one tick later: standby, write interval, output disabled and read. It checks that each timing flag appears only on the tick after a close or an open seen at the control pins, and that a read followed by an external drive reports contention. Only the bench's scenarios can show what was actually stored: which byte lands where, that the last in-window data wins, that a violating write still commits, and that the flag values are correct for chosen widths near each limit.

// File: rtl/sramw_pkg.sv
package sramw_pkg;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic we_n;
    logic oe_n;
  } ctl_t;

  function automatic logic wr_window(ctl_t c);
    return !c.cs1_n && c.cs2 && !c.we_n;
  endfunction

  function automatic logic rd_drive(ctl_t c);
    return !c.cs1_n && c.cs2 && c.we_n && !c.oe_n;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sramw_satcnt.sv
module sramw_satcnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = '1;
  localparam logic [W-1:0] CntOne = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= CntOne;
    else if (inc_i && cnt_q != CntMax)  cnt_q <= cnt_q + CntOne;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sramw_window.sv
module sramw_window #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  output logic             start_o,
  output logic             close_o,
  output logic [CNT_W-1:0] width_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= open_i;
  end

  assign start_o = open_i & ~open_q;
  assign close_o = ~open_i & open_q;

  // counts open samples, first one included
  sramw_satcnt #(.W(CNT_W)) i_width_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_o),
    .inc_i  (open_i),
    .cnt_o  (width_o)
  );
endmodule

// File: rtl/sramw_timing.sv
module sramw_timing #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned TWP_TICKS = 4,
  parameter int unsigned TDW_TICKS = 3,
  parameter int unsigned TWC_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              close_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] din_last_o,
  output logic              wp_viol_o,
  output logic              dw_viol_o,
  output logic              wc_viol_o
);
  localparam logic [CNT_W-1:0] TwpLim = CNT_W'(TWP_TICKS);
  localparam logic [CNT_W-1:0] TdwLim = CNT_W'(TDW_TICKS);
  localparam logic [CNT_W-1:0] TwcLim = CNT_W'(TWC_TICKS);

  logic [DATA_W-1:0] din_q;
  logic [CNT_W-1:0]  age;
  logic [CNT_W-1:0]  gap;
  logic              seen_q;
  logic              din_chg;
  logic              wp_q, dw_q, wc_q;

  assign din_chg = (din_i != din_q);

  sramw_satcnt #(.W(CNT_W)) i_age_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (din_chg),
    .inc_i  (1'b1),
    .cnt_o  (age)
  );

  sramw_satcnt #(.W(CNT_W)) i_gap_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .inc_i  (1'b1),
    .cnt_o  (gap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= '0;
      seen_q <= 1'b0;
      wp_q   <= 1'b0;
      dw_q   <= 1'b0;
      wc_q   <= 1'b0;
    end else begin
      din_q  <= din_i;
      wp_q   <= close_i && (width_i < TwpLim);
      dw_q   <= close_i && (age < TdwLim);
      wc_q   <= start_i && seen_q && (gap < TwcLim);
      if (start_i) seen_q <= 1'b1;
    end
  end

  assign din_last_o = din_q;
  assign wp_viol_o  = wp_q;
  assign dw_viol_o  = dw_q;
  assign wc_viol_o  = wc_q;
endmodule

// File: rtl/sramw_array.sv
module sramw_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sramw_model.sv
module sramw_model
  import sramw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TWP_TICKS = 4,
  parameter int unsigned TDW_TICKS = 3,
  parameter int unsigned TWC_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ext_drv_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              wp_viol_o,
  output logic              dw_viol_o,
  output logic              wc_viol_o,
  output logic              contention_o
);
  localparam int unsigned LimMax = max3(TWP_TICKS, TDW_TICKS, TWC_TICKS);
  localparam int unsigned CntW   = $clog2(LimMax + 1) + 1;

  ctl_t              ctl;
  logic              open_w;
  logic              start_w, close_w;
  logic [CntW-1:0]   width_w;
  logic [DATA_W-1:0] din_last;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] addr_q;
  logic              drv_q;

  assign ctl    = '{cs1_n: cs1_ni, cs2: cs2_i, we_n: we_ni, oe_n: oe_ni};
  assign open_w = wr_window(ctl);

  sramw_window #(.CNT_W(CntW)) i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .open_i  (open_w),
    .start_o (start_w),
    .close_o (close_w),
    .width_o (width_w)
  );

  sramw_timing #(
    .DATA_W    (DATA_W),
    .CNT_W     (CntW),
    .TWP_TICKS (TWP_TICKS),
    .TDW_TICKS (TDW_TICKS),
    .TWC_TICKS (TWC_TICKS)
  ) i_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .close_i    (close_w),
    .width_i    (width_w),
    .din_i      (din_i),
    .din_last_o (din_last),
    .wp_viol_o  (wp_viol_o),
    .dw_viol_o  (dw_viol_o),
    .wc_viol_o  (wc_viol_o)
  );

  // addr_q doubles as last in-window write address and registered read address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      addr_q <= addr_i;
      drv_q  <= rd_drive(ctl);
    end
  end

  sramw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i   (clk_i),
    .wr_i    (close_w),
    .waddr_i (addr_q),
    .wdata_i (din_last),
    .raddr_i (addr_q),
    .rdata_o (rdata)
  );

  assign dout_en_o    = drv_q;
  assign dout_o       = drv_q ? rdata : '0;
  assign contention_o = drv_q & ext_drv_i;
endmodule

// File: rtl/sramw_chk.sv
module sramw_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs1_ni,
  input logic cs2_i,
  input logic we_ni,
  input logic oe_ni,
  input logic ext_drv_i,
  input logic dout_en_o,
  input logic wp_viol_o,
  input logic dw_viol_o,
  input logic wc_viol_o,
  input logic contention_o
);
  logic win_w, rd_w;
  assign win_w = !cs1_ni && cs2_i && !we_ni;
  assign rd_w  = !cs1_ni && cs2_i && we_ni && !oe_ni;

  assert_standby_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs1_ni || !cs2_i) |=> !dout_en_o);

  assert_write_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_w |=> !dout_en_o);

  assert_oe_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !dout_en_o);

  assert_read_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_w |=> dout_en_o);

  assert_close_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_viol_o || dw_viol_o) |-> (!$past(win_w) && $past(win_w, 2)));

  assert_open_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wc_viol_o |-> ($past(win_w) && !$past(win_w, 2)));

  assert_contention_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rd_w) && ext_drv_i) |-> contention_o);
endmodule

bind sramw_model sramw_chk i_sramw_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs1_ni       (cs1_ni),
  .cs2_i        (cs2_i),
  .we_ni        (we_ni),
  .oe_ni        (oe_ni),
  .ext_drv_i    (ext_drv_i),
  .dout_en_o    (dout_en_o),
  .wp_viol_o    (wp_viol_o),
  .dw_viol_o    (dw_viol_o),
  .wc_viol_o    (wc_viol_o),
  .contention_o (contention_o)
);

// File: tb/test_sramw_model.sv
`timescale 1ns/1ps
module test_sramw_model;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int TWP = 4;
  localparam int TDW = 3;
  localparam int TWC = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1, ext = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en, wp, dw, wc, con;

  always #4 clk = ~clk;

  sramw_model #(
    .ADDR_W(AW), .DATA_W(DW), .TWP_TICKS(TWP), .TDW_TICKS(TDW), .TWC_TICKS(TWC)
  ) i_sramw_model (
    .clk_i(clk), .rst_ni(rst_ni), .cs1_ni(cs1_n), .cs2_i(cs2), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .din_i(din), .ext_drv_i(ext), .dout_o(dout), .dout_en_o(dout_en),
    .wp_viol_o(wp), .dw_viol_o(dw), .wc_viol_o(wc), .contention_o(con)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        en;
    logic [DW-1:0] dat;
    logic        wp, dw, wc, con;
    string       req;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] shadow [1 << AW];
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  // monitor: pops expectations when their tick arrives
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      n_run++;
      if (e.due != cyc) begin
        n_fail++;
        $display("FAIL %s: sampled at tick %0d, expected tick %0d", e.req, cyc, e.due);
      end else if ({dout_en, dout, wp, dw, wc, con} !== {e.en, e.dat, e.wp, e.dw, e.wc, e.con}) begin
        n_fail++;
        $display("FAIL %s: got en=%b dout=%h wp=%b dw=%b wc=%b con=%b, expected en=%b dout=%h wp=%b dw=%b wc=%b con=%b",
                 e.req, dout_en, dout, wp, dw, wc, con, e.en, e.dat, e.wp, e.dw, e.wc, e.con);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_next(logic en, logic [DW-1:0] dat, logic ewp, logic edw,
                             logic ewc, logic econ, string req);
    exp_t e;
    e.due = cyc + 1; e.en = en; e.dat = dat;
    e.wp = ewp; e.dw = edw; e.wc = ewc; e.con = econ; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    step();
    cs1_n = 1'b1; cs2 = 1'b0; we_n = 1'b1; oe_n = 1'b1; ext = 1'b0;
    repeat (n) step();
  endtask

  // end_by: 0 write strobe rises, 1 select 1 rises, 2 select 2 falls
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, int width, int end_by,
                          bit late, logic [DW-1:0] late_d, logic exp_wc, string req);
    logic ewp, edw;
    step();
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; ext = 1'b0; addr = a; din = d;
    step();
    we_n = 1'b0;
    expect_next(1'b0, '0, 1'b0, 1'b0, exp_wc, 1'b0, {req, " open"});
    if (late) begin
      repeat (width - 1) step();
      din = late_d;
      step();
    end else begin
      repeat (width) step();
    end
    case (end_by)
      1:       cs1_n = 1'b1;
      2:       cs2 = 1'b0;
      default: we_n = 1'b1;
    endcase
    ewp = (width < TWP);
    edw = late ? (1 < TDW) : ((width + 1) < TDW);
    expect_next(1'b0, '0, ewp, edw, 1'b0, 1'b0, {req, " close"});
    shadow[a] = late ? late_d : d;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic e, string req);
    step();
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0; ext = e; addr = a;
    expect_next(1'b1, shadow[a], 1'b0, 1'b0, 1'b0, e, req);
  endtask

  // no-write probes only: never all of c1=0, c2=1, w=0
  task automatic probe(logic c1, logic c2, logic w, logic o, logic e, string req);
    logic en;
    step();
    cs1_n = c1; cs2 = c2; we_n = w; oe_n = o; ext = e; din = ~shadow[addr];
    en = !c1 && c2 && w && !o;
    expect_next(en, en ? shadow[addr] : '0, 1'b0, 1'b0, 1'b0, en && e, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    expect_next(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R13 reset state");
    idle(TWC);

    do_write(8'h10, 8'h5A, 5, 0, 0, '0, 1'b0, "R1 write by strobe");
    idle(TWC);
    do_read(8'h10, 1'b0, "R4 read back");
    idle(TWC);
    do_write(8'h20, 8'hC3, TWP, 1, 0, '0, 1'b0, "R2 close by select 1");
    idle(TWC);
    do_write(8'h30, 8'h7E, 6, 2, 0, '0, 1'b0, "R2 close by select 2");
    idle(TWC);
    do_read(8'h20, 1'b0, "R5 addr 20");
    do_read(8'h30, 1'b0, "R5 addr 30");
    do_read(8'h10, 1'b0, "R5 addr 10");

    probe(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 output disabled");
    probe(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6 select 1 high");
    probe(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 select 2 low");
    probe(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 both off");
    do_read(8'h10, 1'b0, "R1 no write outside window");
    idle(TWC);

    do_write(8'h40, 8'h11, 5, 0, 1, 8'h22, 1'b0, "R3 R10 late data");
    idle(TWC);
    do_read(8'h40, 1'b0, "R3 last in-window data");
    idle(TWC);

    do_write(8'h50, 8'h99, 2, 0, 0, '0, 1'b0, "R9 short pulse");
    idle(TWC);
    do_read(8'h50, 1'b0, "R9 short write committed");
    idle(TWC);

    do_write(8'h60, 8'hA1, 4, 0, 0, '0, 1'b0, "R11 first");
    do_write(8'h61, 8'hB2, 4, 0, 0, '0, 1'b1, "R11 too close");
    idle(TWC);
    do_write(8'h62, 8'hC4, 4, 0, 0, '0, 1'b0, "R11 spaced");
    idle(TWC);
    do_read(8'h61, 1'b0, "R11 second write committed");
    idle(TWC);

    // R7: select 1 and strobe fall together with output enable low
    step();
    cs1_n = 1'b1; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = 8'h70; din = 8'h3C;
    step();
    cs1_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    expect_next(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 hi-z at open");
    repeat (2) step();
    expect_next(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 hi-z inside window");
    repeat (TWP - 2) step();
    we_n = 1'b1;
    shadow[8'h70] = 8'h3C;
    expect_next(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R7 read after close");
    idle(TWC);

    do_read(8'h30, 1'b1, "R12 contention");
    probe(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R12 no contention when disabled");
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule